// File: doc/BRIEF.md
# Coincidence Count Trigger Framer

Each bunch crossing this block receives one 8-bit trigger byte from each of twelve slots and derives eight independent trigger bits from them. For every trigger bit, each slot's byte is first masked by that trigger's own per-slot mask. A slot counts as a hit when any unmasked bit of its byte is set. The number of hit slots, from 0 to 12, is then compared with that trigger's 4-bit threshold.

The eight results, the crossing number and the orbit-start flag go out as a four-byte frame on a byte stream that runs four bytes per crossing. The frame opens with a comma character, which is marked by a K flag for the line encoder downstream. Encoding and serialization take place outside the block.

The crossing strobe marks the cycle in which the slot bytes, crossing ID and orbit flag are valid. The frame that carries the results of a crossing starts on the following strobe.

Top module: `coinc_trig_framer`

## Requirements
- R1: While reset is held low, and after it is released until the first frame, `out_byte` is 0x00 and `out_k` is 0.
- R2: Slot s supplies bits `slot_bytes[8*s+7:8*s]`. For trigger t, the mask byte of slot s is `mask_cfg[8*(12*t+s)+7 : 8*(12*t+s)]`. A mask bit of 1 removes that input bit. A slot is a hit for trigger t when its byte ANDed with the inverted mask is non-zero.
- R3: Trigger t fires when its hit count is greater than or equal to `thresh_cfg[4*t+3:4*t]`. A threshold of 0 always fires. Thresholds of 13 to 15 never fire.
- R4: The eight triggers are evaluated independently. Bit t of the trigger word is the result of trigger t.
- R5: Frame byte 0 is 0xBC with `out_k` = 1. `out_k` is 0 on every other byte.
- R6: Frame byte 1 holds the orbit-start flag in bit 7, the constant 3'b001 in bits 6:4, and crossing ID bits 11:8 in bits 3:0.
- R7: Frame byte 2 is crossing ID bits 7:0. Frame byte 3 is the trigger word.
- R8: Slot bytes, crossing ID and orbit flag are sampled only in the cycle `xing_stb` is high. The frame for that crossing starts in the cycle after the next strobe edge. Its four bytes appear on consecutive cycles. Strobes must be at least four cycles apart, and the mask and threshold configuration must be stable from a strobe through the cycle after it.
- R9: A strobe that arrives before any crossing has been captured starts no frame. After frame byte 3, the output is 0x00 with `out_k` = 0 until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock, four cycles per crossing |
| rst_n | input | 1 | Synchronous active-low reset |
| xing_stb | input | 1 | High for one cycle per crossing when the inputs are valid |
| xing_id | input | 12 | Crossing number of the current crossing |
| orbit_start | input | 1 | Set on the first crossing of an orbit |
| slot_bytes | input | 96 | Twelve slot trigger bytes, slot 0 in the low byte |
| mask_cfg | input | 768 | Per-trigger, per-slot mask bytes, 1 disables a bit |
| thresh_cfg | input | 32 | Eight 4-bit count thresholds |
| out_byte | output | 8 | Frame byte stream |
| out_k | output | 1 | Marks the comma byte as a control character |

## Verification
A wrong hit count or comparison appears at the ports one crossing later, as a wrong bit in frame byte 3. A misrouted mask slice does the same, but only under masks and sparse slot bytes that make the affected slot decide the count, which is why the stimulus spreads the hit counts across the whole 0 to 12 range. A broken byte sequencer shows up within the four cycles after a strobe, as a misplaced comma, K flag or header field. A pipeline that captures at the wrong time shows up as frame contents that follow the junk driven on the inputs between strobes.

// File: rtl/ctf_pkg.sv
// Shared constants and payload type for the coincidence count trigger framer.
// Assumes eight triggers and a 12-bit crossing ID, both fixed by the frame layout.
package ctf_pkg;
    localparam int unsigned N_TRIG    = 8;
    localparam int unsigned XID_W     = 12;
    localparam logic [7:0]  COMMA_K   = 8'hBC;
    localparam logic [2:0]  FRAME_VER = 3'd1;
    localparam int unsigned FRAME_LEN = 4;

    // One crossing's worth of framed results
    typedef struct packed {
        logic              orbit;
        logic [XID_W-1:0]  xid;
        logic [N_TRIG-1:0] trig;
    } ctf_payload_t;
endpackage

// File: rtl/ctf_xing_capture.sv
// Registers the slot bytes, crossing ID and orbit flag on the crossing strobe,
// and raises a one-cycle pulse the cycle after a capture.
// Assumes inputs are valid during the strobe cycle only.
module ctf_xing_capture #(
    parameter int unsigned N_SLOTS = 12,
    parameter int unsigned SLOT_W  = 8,
    parameter int unsigned XID_W   = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       stb,
    input  logic [N_SLOTS*SLOT_W-1:0]  slots_in,
    input  logic [XID_W-1:0]           xid_in,
    input  logic                       orbit_in,
    output logic [N_SLOTS*SLOT_W-1:0]  slots_q,
    output logic [XID_W-1:0]           xid_q,
    output logic                       orbit_q,
    output logic                       cap_pulse
);
    // Hold the crossing inputs from one strobe to the next
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots_q <= '0;
            xid_q   <= '0;
            orbit_q <= 1'b0;
        end else if (stb) begin
            slots_q <= slots_in;
            xid_q   <= xid_in;
            orbit_q <= orbit_in;
        end
    end

    // Flag the cycle in which freshly captured data is available
    always_ff @(posedge clk) begin
        if (!rst_n) cap_pulse <= 1'b0;
        else        cap_pulse <= stb;
    end
endmodule

// File: rtl/ctf_coinc_unit.sv
// One coincidence trigger: masks each slot byte, counts the slots with any
// unmasked bit set and compares the count with a threshold (count >= thr).
// Purely combinational; the caller registers the result.
module ctf_coinc_unit #(
    parameter int unsigned N_SLOTS = 12,
    parameter int unsigned SLOT_W  = 8,
    parameter int unsigned THR_W   = 4
) (
    input  logic [N_SLOTS*SLOT_W-1:0] slots,
    input  logic [N_SLOTS*SLOT_W-1:0] mask,
    input  logic [THR_W-1:0]          thr,
    output logic                      fire
);
    localparam int unsigned CNT_W = $clog2(N_SLOTS + 1);
    localparam int unsigned CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

    logic [N_SLOTS-1:0] hit;
    logic [CNT_W-1:0]   cnt;

    // Per-slot hit detection after masking
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        assign hit[s] = |(slots[s*SLOT_W +: SLOT_W] & ~mask[s*SLOT_W +: SLOT_W]);
    end

    // Population count of the hit slots
    always_comb begin
        cnt = '0;
        for (int s = 0; s < N_SLOTS; s++) begin
            cnt = cnt + CNT_W'(hit[s]);
        end
    end

    // Threshold comparison at a common width
    assign fire = (CMP_W'(cnt) >= CMP_W'(thr));
endmodule

// File: rtl/ctf_frame_tx.sv
// Emits the four-byte frame: comma (K flag), header, crossing ID low byte,
// trigger word. A frame starts on a strobe when a payload is held; between
// frames the output idles at zero. Assumes strobes at least FRAME_LEN apart.
module ctf_frame_tx
    import ctf_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb,
    input  logic         pay_valid,
    input  ctf_payload_t pay,
    output logic [7:0]   out_byte,
    output logic         out_k
);
    localparam int unsigned IDX_W = $clog2(FRAME_LEN);

    ctf_payload_t     hold_q;
    logic             busy_q;
    logic [IDX_W-1:0] idx_q;
    logic [7:0]       body_byte;

    // Select the frame body byte for the current position
    always_comb begin
        unique case (idx_q)
            IDX_W'(1): body_byte = {hold_q.orbit, FRAME_VER, hold_q.xid[11:8]};
            IDX_W'(2): body_byte = hold_q.xid[7:0];
            IDX_W'(3): body_byte = hold_q.trig;
            default:   body_byte = 8'h00;
        endcase
    end

    // Sequence the frame bytes and idle between frames
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= 8'h00;
            out_k    <= 1'b0;
            busy_q   <= 1'b0;
            idx_q    <= '0;
            hold_q   <= '0;
        end else if (stb && pay_valid) begin
            out_byte <= COMMA_K;
            out_k    <= 1'b1;
            hold_q   <= pay;
            busy_q   <= 1'b1;
            idx_q    <= IDX_W'(1);
        end else if (busy_q) begin
            out_byte <= body_byte;
            out_k    <= 1'b0;
            idx_q    <= idx_q + IDX_W'(1);
            if (idx_q == IDX_W'(FRAME_LEN - 1)) busy_q <= 1'b0;
        end else begin
            out_byte <= 8'h00;
            out_k    <= 1'b0;
        end
    end
endmodule

// File: rtl/coinc_trig_framer.sv
// Top of the coincidence count trigger framer. Captures a crossing on the
// strobe, evaluates eight masked-count triggers the cycle after, and frames
// the result on the following strobe. Configuration must be stable from a
// strobe through the next cycle.
module coinc_trig_framer
    import ctf_pkg::*;
#(
    parameter int unsigned N_SLOTS = 12,
    parameter int unsigned SLOT_W  = 8,
    parameter int unsigned THR_W   = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              xing_stb,
    input  logic [XID_W-1:0]                  xing_id,
    input  logic                              orbit_start,
    input  logic [N_SLOTS*SLOT_W-1:0]         slot_bytes,
    input  logic [N_TRIG*N_SLOTS*SLOT_W-1:0]  mask_cfg,
    input  logic [N_TRIG*THR_W-1:0]           thresh_cfg,
    output logic [7:0]                        out_byte,
    output logic                              out_k
);
    localparam int unsigned MASK_PER_TRIG = N_SLOTS * SLOT_W;

    logic [N_SLOTS*SLOT_W-1:0] slots_q;
    logic [XID_W-1:0]          xid_q;
    logic                      orbit_q;
    logic                      cap_pulse;
    logic [N_TRIG-1:0]         trig_now;
    ctf_payload_t              pay_q;
    logic                      pay_valid;

    ctf_xing_capture #(
        .N_SLOTS (N_SLOTS),
        .SLOT_W  (SLOT_W),
        .XID_W   (XID_W)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (xing_stb),
        .slots_in  (slot_bytes),
        .xid_in    (xing_id),
        .orbit_in  (orbit_start),
        .slots_q   (slots_q),
        .xid_q     (xid_q),
        .orbit_q   (orbit_q),
        .cap_pulse (cap_pulse)
    );

    for (genvar t = 0; t < N_TRIG; t++) begin : g_trig
        ctf_coinc_unit #(
            .N_SLOTS (N_SLOTS),
            .SLOT_W  (SLOT_W),
            .THR_W   (THR_W)
        ) u_unit (
            .slots (slots_q),
            .mask  (mask_cfg[t*MASK_PER_TRIG +: MASK_PER_TRIG]),
            .thr   (thresh_cfg[t*THR_W +: THR_W]),
            .fire  (trig_now[t])
        );
    end

    // Register the evaluated crossing as the next frame payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pay_q     <= '0;
            pay_valid <= 1'b0;
        end else if (cap_pulse) begin
            pay_q.orbit <= orbit_q;
            pay_q.xid   <= xid_q;
            pay_q.trig  <= trig_now;
            pay_valid   <= 1'b1;
        end
    end

    ctf_frame_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb       (xing_stb),
        .pay_valid (pay_valid),
        .pay       (pay_q),
        .out_byte  (out_byte),
        .out_k     (out_k)
    );
endmodule

// File: rtl/ctf_framer_checker.sv
// Protocol checks on the framer output, bound to the top module.
module ctf_framer_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       xing_stb,
    input logic       pay_valid,
    input logic [7:0] out_byte,
    input logic       out_k
);
    AST_K_IS_COMMA: assert property (@(posedge clk) disable iff (!rst_n)
        out_k |-> out_byte == 8'hBC); // R5
    AST_K_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_k |=> !out_k); // R5
    AST_HDR_VERSION: assert property (@(posedge clk) disable iff (!rst_n)
        out_k |=> out_byte[6:4] == 3'b001); // R6
    AST_FRAME_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (xing_stb && pay_valid) |=> out_k); // R8
    AST_NO_EARLY_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !pay_valid |=> !out_k); // R9
endmodule

bind coinc_trig_framer ctf_framer_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xing_stb  (xing_stb),
    .pay_valid (pay_valid),
    .out_byte  (out_byte),
    .out_k     (out_k)
);

// File: tb/coinc_trig_framer_tb.sv
module coinc_trig_framer_tb;
    localparam int NS = 12;
    localparam int NT = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xing_stb = 1'b0;
    logic [11:0]   xing_id = '0;
    logic          orbit_start = 1'b0;
    logic [95:0]   slot_bytes = '0;
    logic [767:0]  mask_cfg = '0;
    logic [31:0]   thresh_cfg = '0;
    logic [7:0]    out_byte;
    logic          out_k;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic       p_valid = 1'b0;
    logic [7:0] p_b1, p_b2, p_b3;

    coinc_trig_framer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .xing_stb    (xing_stb),
        .xing_id     (xing_id),
        .orbit_start (orbit_start),
        .slot_bytes  (slot_bytes),
        .mask_cfg    (mask_cfg),
        .thresh_cfg  (thresh_cfg),
        .out_byte    (out_byte),
        .out_k       (out_k)
    );

    always #4 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL R8 watchdog: actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    // Expected trigger word computed from the requirement text
    function automatic logic [7:0] exp_trig(input logic [95:0] sb, input logic [767:0] mk,
                                            input logic [31:0] th);
        logic [7:0] r;
        for (int t = 0; t < NT; t++) begin
            int cnt = 0;
            for (int s = 0; s < NS; s++) begin
                if ((sb[s*8 +: 8] & ~mk[(t*NS+s)*8 +: 8]) != 8'h00) cnt++;
            end
            r[t] = (cnt >= int'(th[t*4 +: 4]));
        end
        return r;
    endfunction

    // One crossing: drive inputs, then check the previous crossing's frame
    task automatic xing(input logic [95:0] sb, input logic [11:0] id, input logic orb, input int gap);
        logic [7:0] e3;
        e3 = exp_trig(sb, mask_cfg, thresh_cfg);
        xing_stb = 1'b1; slot_bytes = sb; xing_id = id; orbit_start = orb;
        @(negedge clk);
        xing_stb = 1'b0;
        slot_bytes = {$urandom, $urandom, $urandom};
        xing_id = 12'($urandom); orbit_start = 1'($urandom);
        if (p_valid) begin
            chk("R5 comma byte", out_byte, 8'hBC);
            chk("R5 K flag on byte 0", {7'd0, out_k}, 8'd1);
        end else begin
            chk("R9 no frame before capture", out_byte, 8'h00);
            chk("R9 no K before capture", {7'd0, out_k}, 8'd0);
        end
        @(negedge clk);
        chk(p_valid ? "R6 header byte" : "R9 idle byte", out_byte, p_valid ? p_b1 : 8'h00);
        chk("R5 K low on byte 1", {7'd0, out_k}, 8'd0);
        @(negedge clk);
        chk(p_valid ? "R7 ID low byte" : "R9 idle byte", out_byte, p_valid ? p_b2 : 8'h00);
        @(negedge clk);
        chk(p_valid ? "R7 trigger word (R2 R3 R4 R8)" : "R9 idle byte", out_byte,
            p_valid ? p_b3 : 8'h00);
        chk("R5 K low on byte 3", {7'd0, out_k}, 8'd0);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            chk("R9 idle after frame", out_byte, 8'h00);
            chk("R9 idle K", {7'd0, out_k}, 8'd0);
        end
        p_valid = 1'b1;
        p_b1 = {orb, 3'b001, id[11:8]};
        p_b2 = id[7:0];
        p_b3 = e3;
    endtask

    function automatic logic [7:0] rnd_slot();
        return ($urandom % 2 == 0) ? 8'h00 : 8'(1 << ($urandom % 8));
    endfunction

    initial begin
        logic [95:0] sb;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R1 reset byte", out_byte, 8'h00);
        chk("R1 reset K", {7'd0, out_k}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", out_byte, 8'h00);

        // Directed: zero bytes, threshold 0 on every trigger fires all (R3)
        mask_cfg = '0; thresh_cfg = '0;
        xing('0, 12'hABC, 1'b1, 0);
        // Directed: all inputs masked, only threshold 0 fires (R2)
        mask_cfg = '1; thresh_cfg = 32'h7654_3210;
        xing('1, 12'h5A3, 1'b0, 0);
        // Directed: all 12 hit; thresholds 12 fire, 13 and 15 never (R3)
        mask_cfg = '0; thresh_cfg = 32'h0C01_BFDC;
        xing({NS{8'h01}}, 12'h001, 1'b0, 1);
        // Directed: six hits; one slot masked only for trigger 2 (R2 R4)
        mask_cfg = '0;
        mask_cfg[(2*NS+0)*8 +: 8] = 8'h80;
        mask_cfg[(5*NS+7)*8 +: 8] = 8'hFF;
        thresh_cfg = 32'h6666_6666;
        sb = '0;
        for (int s = 0; s < 6; s++) sb[s*8 +: 8] = 8'h80;
        xing(sb, 12'hF00, 1'b1, 0);

        // Random crossings with spread hit counts and gaps
        for (int n = 0; n < 60; n++) begin
            for (int w = 0; w < 24; w++) mask_cfg[w*32 +: 32] = $urandom & $urandom;
            thresh_cfg = $urandom;
            for (int s = 0; s < NS; s++) sb[s*8 +: 8] = rnd_slot();
            xing(sb, 12'($urandom), 1'($urandom), int'($urandom % 3));
        end
        xing('0, 12'h000, 1'b0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule